// File: doc/BRIEF.md
# Multi-Mode DMA Bus Master

This block moves words between up to four peripherals and a shared synchronous memory while acting as bus master. A peripheral raises its request line, and the controller asks the host processor for the bus with a hold request. Once the host grants the bus, the controller answers the peripheral on its acknowledge line. The controller supplies the memory address from that channel's own address register and strobes memory for either a read or a write. While acknowledge is high, the peripheral exchanges one data word. On the word that uses up the channel's programmed count, the terminal-count output rises together with that acknowledge.

Each channel is loaded in one cycle through a write port that carries a start address, a word count, a direction and a bus-acquisition mode. The controller supports three acquisition modes. Block mode keeps the bus for the whole count. Cycle-stealing mode gives the bus back after every word. Interleaved mode takes the bus only while the host reports that it is idle. When several channels request at once, the lowest-numbered one wins. Arbitration happens only between bus tenures.

Top module: `dma_master`

## Requirements
- R1: Memory strobes, memory address, memory write data, read data passed to the peripheral, and every acknowledge are low/zero unless `hold` and `hlda` are both high.
- R2: Acknowledge is at most one-hot and is given only to a channel whose request is high. With direction 1 (peripheral to memory), `mem_wr` is high and `mem_wdata` equals `per_wdata`. With direction 0 (memory to peripheral), `mem_rd` is high and `per_rdata` equals `mem_rdata`.
- R3: `tc` is high in exactly the cycle of a channel's final acknowledge and at no other time.
- R4: In mode 00 (block), `hold` rises once per programmed count and stays high through gaps in the request.
- R5: In mode 01 (cycle stealing), each word is followed by `hold` low in the next cycle, so each grant carries exactly one word.
- R6: In mode 10 (interleaved), a word moves only in a cycle where `cpu_idle` is high. Mode 11 behaves as block.
- R7: When several enabled channels request together from idle, the lowest-numbered channel is served first.
- R8: Each word uses the channel's current address. The address then increases by one and the count decreases by one. During request gaps, both are kept unchanged.
- R9: A channel whose count is exhausted gives no further acknowledge and no `hold` until it is programmed again, even if its request stays high.
- R10: Programming a count of zero leaves the channel disabled, so its request causes no `hold`.
- R11: After reset, `hold`, `tc`, all acknowledges and both strobes are low, and every channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Program the channel selected by `cfg_sel` |
| cfg_sel | input | SW | Channel to program |
| cfg_addr | input | AW | Start address |
| cfg_count | input | CW | Number of words; zero leaves the channel off |
| cfg_dir | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| cfg_mode | input | 2 | 00 block, 01 cycle stealing, 10 interleaved, 11 block |
| hold | output | 1 | Bus request to the host |
| hlda | input | 1 | Bus grant from the host |
| cpu_idle | input | 1 | Host is doing internal work and does not need the bus |
| drq | input | NCH | Per-channel transfer request |
| dack | output | NCH | Per-channel transfer acknowledge |
| tc | output | 1 | Terminal count, high with the final acknowledge |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the strobe cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| per_wdata | input | DW | Word from the acknowledged peripheral |
| per_rdata | output | DW | Word to the acknowledged peripheral |

## Verification
The assertions assume a host that keeps `hlda` high while `hold` is high after granting it, and does not withdraw the grant in the middle of a tenure. They also assume a memory that returns read data in the same cycle as the strobe. The bench host model raises and lowers `hlda` one cycle after `hold` and never revokes it early. Its memory answers combinationally, and it never reprograms a channel while that channel is being served. Requests and `cpu_idle` are randomised each cycle within these limits, so every mode meets gaps and idle windows.

// File: rtl/dma_master.sv
module dma_master #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 16,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_dir,
  input  logic [1:0]    cfg_mode,
  output logic          hold,
  input  logic          hlda,
  input  logic          cpu_idle,
  input  logic [NCH-1:0] drq,
  output logic [NCH-1:0] dack,
  output logic          tc,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] per_wdata,
  output logic [DW-1:0] per_rdata
);
  localparam logic [1:0] M_STEAL = 2'b01;
  localparam logic [1:0] M_INTL  = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER, S_REL} state_t;

  state_t        st;
  logic [SW-1:0] cur;
  logic [AW-1:0] addr_q [NCH];
  logic [CW-1:0] cnt_q  [NCH];
  logic          en_q   [NCH];
  logic          dir_q  [NCH];
  logic [1:0]    mode_q [NCH];

  logic [1:0]    cm;
  logic          word, last, pick_ok;
  logic [SW-1:0] pick;

  assign cm   = mode_q[cur];
  assign word = (st == S_XFER) && hlda && drq[cur] && (cm != M_INTL || cpu_idle);
  assign last = word && (cnt_q[cur] == CW'(1));

  assign hold      = (st == S_REQ) || (st == S_XFER);
  assign tc        = last;
  assign mem_wr    = word && dir_q[cur];
  assign mem_rd    = word && !dir_q[cur];
  assign mem_addr  = word ? addr_q[cur] : '0;
  assign mem_wdata = mem_wr ? per_wdata : '0;
  assign per_rdata = mem_rd ? mem_rdata : '0;

  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (en_q[i] && drq[i] && (mode_q[i] != M_INTL || cpu_idle)) begin
        pick_ok = 1'b1;
        pick    = SW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cur <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (pick_ok) begin
          cur <= pick;
          st  <= S_REQ;
        end
        S_REQ:  if (hlda) st <= S_XFER;
        S_XFER: begin
          if (last)                                      st <= S_REL;
          else if (word && cm == M_STEAL)                st <= S_REL;
          else if (!word && cm == M_INTL)                st <= S_REL;
        end
        S_REL:  if (!hlda) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_g, busy_g;
    assign sel_g   = (cur == SW'(g));
    assign busy_g  = (st != S_IDLE) && sel_g;
    assign dack[g] = word && sel_g;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        cnt_q[g]  <= '0;
        en_q[g]   <= 1'b0;
        dir_q[g]  <= 1'b0;
        mode_q[g] <= '0;
      end else if (cfg_we && cfg_sel == SW'(g) && !busy_g) begin
        addr_q[g] <= cfg_addr;
        cnt_q[g]  <= cfg_count;
        en_q[g]   <= (cfg_count != '0);
        dir_q[g]  <= cfg_dir;
        mode_q[g] <= cfg_mode;
      end else if (dack[g]) begin
        addr_q[g] <= addr_q[g] + AW'(1);
        cnt_q[g]  <= cnt_q[g] - CW'(1);
        if (cnt_q[g] == CW'(1)) en_q[g] <= 1'b0;
      end
    end
  end

  a_r1_owned_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || (dack != '0)) |-> (hold && hlda));

  a_r2_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  a_r2_ack_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0) |-> ((dack & drq) != '0));

  a_r3_tc_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (dack != '0));

  a_r4_block_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && cm != M_STEAL && cm != M_INTL && !last) |=> hold);

  a_r5_steal_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (word && cm == M_STEAL) |=> !hold);

  a_r6_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    (word && cm == M_INTL) |-> cpu_idle);
endmodule

// File: tb/dma_master_bench.sv
module dma_master_bench;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int CW  = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [AW-1:0] cfg_addr = 0;
  logic [CW-1:0] cfg_count = 0;
  logic cfg_dir = 0;
  logic [1:0] cfg_mode = 0;
  logic hold, hlda = 0, cpu_idle = 0, tc, mem_rd, mem_wr;
  logic [NCH-1:0] drq = 0, dack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, per_wdata, per_rdata;

  logic [DW-1:0] mem [256];
  logic [AW-1:0] exp_addr [NCH];
  int            exp_cnt  [NCH];
  logic          exp_dir  [NCH];
  logic [1:0]    exp_mode [NCH];
  logic [NCH-1:0] want = 0;
  int drq_pct = 100, idle_pct = 100;
  int total = 0, bad = 0, hold_rises = 0, cyc = 0;
  logic prev_hold = 0, steal_seen = 0, done_flag = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return DW'(a) ^ 16'h3C5A;
  endfunction

  assign mem_rdata = mem[mem_addr[7:0]];
  assign per_wdata = pat(mem_addr);

  dma_master #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_dma_master (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .cfg_dir(cfg_dir),
    .cfg_mode(cfg_mode), .hold(hold), .hlda(hlda), .cpu_idle(cpu_idle),
    .drq(drq), .dack(dack), .tc(tc), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .per_wdata(per_wdata), .per_rdata(per_rdata));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      hlda     <= hold;
      cpu_idle <= ($urandom_range(0, 99) < idle_pct);
      for (int c = 0; c < NCH; c++)
        drq[c] <= want[c] && ($urandom_range(0, 99) < drq_pct);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (hold && !prev_hold) hold_rises++;
        prev_hold = hold;
        if (steal_seen) chk(!hold, "R5", "hold after stolen word", hold, 0);
        steal_seen = 0;
        if (mem_rd || mem_wr || dack != 0)
          chk(hold && hlda, "R1", "bus activity without grant", {hold, hlda}, 2'b11);
        if (dack == 0) begin
          if (tc) chk(0, "R3", "tc without ack", tc, 0);
        end else begin
          int c;
          c = 0;
          for (int i = NCH - 1; i >= 0; i--) if (dack[i]) c = i;
          chk($countones(dack) == 1, "R2", "ack one-hot", dack, 1 << c);
          chk(drq[c], "R2", "ack without request", drq, dack);
          chk(exp_cnt[c] > 0, "R9", "ack on exhausted channel", c, 0);
          chk(mem_addr == exp_addr[c], "R8", "address", mem_addr, exp_addr[c]);
          chk(tc == (exp_cnt[c] == 1), "R3", "tc", tc, exp_cnt[c] == 1);
          if (exp_dir[c]) begin
            chk(mem_wr && !mem_rd, "R2", "write strobe", {mem_wr, mem_rd}, 2'b10);
            chk(mem_wdata == pat(exp_addr[c]), "R2", "write data", mem_wdata, pat(exp_addr[c]));
            mem[mem_addr[7:0]] = mem_wdata;
          end else begin
            chk(mem_rd && !mem_wr, "R2", "read strobe", {mem_wr, mem_rd}, 2'b01);
            chk(per_rdata == mem[exp_addr[c][7:0]], "R2", "read data", per_rdata, mem[exp_addr[c][7:0]]);
          end
          if (exp_mode[c] == 2'b10) chk(cpu_idle, "R6", "word while host busy", cpu_idle, 1);
          if (exp_mode[c] == 2'b01) steal_seen = 1;
          exp_addr[c] = exp_addr[c] + 1;
          exp_cnt[c]  = exp_cnt[c] - 1;
          if (exp_cnt[c] <= 0) begin
            exp_cnt[c] = 0;
            want[c] = 0;
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  task automatic prog(input int ch, input int a, input int n,
                      input logic d, input logic [1:0] m);
    @(posedge clk);
    #1;
    cfg_we = 1; cfg_sel = 2'(ch); cfg_addr = AW'(a); cfg_count = CW'(n);
    cfg_dir = d; cfg_mode = m;
    exp_addr[ch] = AW'(a); exp_cnt[ch] = n; exp_dir[ch] = d; exp_mode[ch] = m;
    @(posedge clk);
    #1;
    cfg_we = 0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while ((want != 0 || hold || hlda) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, "R8", "transfers completed", want, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int r0;
    void'($urandom(32'd7));
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 40503 + 17);
    for (int c = 0; c < NCH; c++) begin
      exp_addr[c] = 0; exp_cnt[c] = 0; exp_dir[c] = 0; exp_mode[c] = 0;
    end
    repeat (3) @(negedge clk);
    chk(!hold && !tc && dack == 0 && !mem_rd && !mem_wr, "R11", "reset outputs",
        {hold, tc, dack, mem_rd, mem_wr}, 0);
    @(posedge clk);
    #1 rst_n = 1;
    want = 4'b1111;
    drq_pct = 100;
    repeat (10) @(negedge clk);
    chk(hold_rises == 0, "R11", "no channel enabled after reset", hold_rises, 0);
    want = 0;
    repeat (3) @(negedge clk);

    drq_pct = 60; idle_pct = 50;
    prog(1, 8'h10, 6, 1, 2'b00);
    r0 = hold_rises; want[1] = 1; wait_done();
    chk(hold_rises - r0 == 1, "R4", "block grants", hold_rises - r0, 1);

    prog(2, 8'h40, 4, 0, 2'b01);
    r0 = hold_rises; want[2] = 1; wait_done();
    chk(hold_rises - r0 == 4, "R5", "steal grants", hold_rises - r0, 4);

    idle_pct = 40;
    prog(3, 8'h60, 7, 1, 2'b10);
    want[3] = 1; wait_done();
    chk(exp_cnt[3] == 0, "R6", "interleaved completion", exp_cnt[3], 0);

    prog(2, 8'h80, 5, 0, 2'b11);
    r0 = hold_rises; want[2] = 1; wait_done();
    chk(hold_rises - r0 == 1, "R6", "mode 11 as block", hold_rises - r0, 1);

    drq_pct = 100; idle_pct = 100;
    prog(2, 8'hA0, 3, 1, 2'b00);
    prog(0, 8'hB0, 3, 0, 2'b00);
    want = 4'b0101;
    begin
      int n;
      n = 0;
      while (dack == 0 && n < 100) begin @(negedge clk); n++; end
      chk(dack == 4'b0001, "R7", "first served channel", dack, 4'b0001);
    end
    wait_done();

    prog(1, 8'hC0, 2, 1, 2'b00);
    want[1] = 1; wait_done();
    r0 = hold_rises;
    want[1] = 1;
    repeat (30) @(negedge clk);
    chk(hold_rises == r0, "R9", "exhausted channel idle", hold_rises - r0, 0);
    want[1] = 0;
    repeat (3) @(negedge clk);

    prog(3, 8'hD0, 0, 0, 2'b00);
    r0 = hold_rises;
    want[3] = 1;
    repeat (20) @(negedge clk);
    chk(hold_rises == r0, "R10", "zero count stays off", hold_rises - r0, 0);
    want[3] = 0;
    repeat (3) @(negedge clk);

    drq_pct = 70; idle_pct = 60;
    for (int round = 0; round < 8; round++) begin
      for (int c = 0; c < NCH; c++)
        prog(c, $urandom_range(0, 255), $urandom_range(1, 9), 1'($urandom_range(0, 1)),
             2'($urandom_range(0, 3)));
      want = 4'b1111;
      wait_done();
      for (int c = 0; c < NCH; c++)
        chk(exp_cnt[c] == 0, "R8", "random round count", exp_cnt[c], 0);
    end

    finish_run();
  end
endmodule